// File: doc/BRIEF.md
# Per-Pin Signal Routing Crossbar

This block decides, for every routable pin, what drives its pad. Each pin has one 8-bit setting byte on a shared register port. When the byte's top bit is set, the pin is under plain GPIO control: its pad output and enable copy that pin's GPIO data and enable bits. When the top bit is clear, the low seven bits name another signal by its global I/O number. The pin's pad is then always driven, with the current synchronized value of that signal.

I/O numbers run from 1 to 83. Numbers 3, 4, 18 and 19 (and 0) cannot be routed. Their setting bytes do not exist: writes to them are dropped, reads give zero, and their pads always follow GPIO. If a routed pin names a source that cannot be routed or that is out of range, the pad is driven high as an idle level. Pad outputs are registered once, so a change of selection never glitches the pad.

Top module: `pin_xbar`

## Requirements
- R1: The setting byte of pin n is at register address 0x80 + n. Writing 0x05 to address 0xA1 makes pin 33 drive the value of I/O 5.
- R2: During reset, pad_out and pad_oe are all zero. After reset, every routable setting byte reads 0x80, which is GPIO mode with source 0.
- R3: When bit 7 of a pin's byte is 1, pad_out and pad_oe of that pin equal its gpio_out and gpio_oe, one clock later. In this mode bits 6:0 are ignored.
- R4: When bit 7 is 0 and bits 6:0 name a routable I/O number s, pad_oe is 1 and pad_out equals sig_in[s], one clock later. Raw sig_in is used, not another pin's pad.
- R5: When bit 7 is 0 and the source is 0, 3, 4, 18, 19 or 84 and above, pad_out and pad_oe are both 1.
- R6: Addresses 0x80 + n for n in {0, 3, 4, 18, 19} and for n from 84 to 127 hold no state. Writes there change nothing, reads return 0, and pins 0, 3, 4, 18 and 19 always follow GPIO.
- R7: A read of a routable pin's address returns the full byte last written there.
- R8: Writes to addresses below 0x80 leave every setting byte unchanged.
- R9: A register write at clock edge k first shows on the pad at edge k+1. A change of gpio or sig_in shows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, used for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| gpio_out | input | 84 | Per-pin GPIO output data, indexed by I/O number |
| gpio_oe | input | 84 | Per-pin GPIO output enable |
| sig_in | input | 84 | Synchronized values of all numbered signals |
| pad_out | output | 84 | Registered pad output value |
| pad_oe | output | 84 | Registered pad output enable |

## Verification
The read port is combinational, so readback is sampled a fraction of a cycle after the address settles. A changed gpio or sig_in value is due at the first edge after it is driven. A setting write is due one edge after the edge that stores it. The bench also checks, at the negative edge between those two edges, that the old routing still holds. Every expected pad value goes into a queue tagged with the clock count at which it is due. The monitor compares it at the negative edge of exactly that count, and a missed count is reported as a failure.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  localparam int SRC_W  = 7;
  localparam int CFG_W  = SRC_W + 1;
  localparam int NUM_IO = 84;

  typedef struct packed {
    logic             gpio_mode;
    logic [SRC_W-1:0] src;
  } xbar_cfg_t;

  localparam xbar_cfg_t CFG_RESET = '{gpio_mode: 1'b1, src: '0};

  // An I/O number can be routed when it lies in 1..num_io-1 and is not
  // one of the fixed, non-routable numbers.
  function automatic bit routable(int n, int num_io);
    if (n < 1 || n >= num_io) return 1'b0;
    case (n)
      3, 4, 18, 19: return 1'b0;
      default:      return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
`timescale 1ns/1ps
module xbar_cfg_regs import xbar_pkg::*; #(
  parameter int NUM_PINS = NUM_IO,
  parameter int ADDR_W   = 8,
  parameter int CFG_BASE = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CFG_W-1:0]          wdata,
  output logic [CFG_W-1:0]          rdata,
  output logic [NUM_PINS*CFG_W-1:0] cfg_flat
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [ADDR_W-1:0] offs;
  logic              in_window;
  logic [IDX_W-1:0]  idx;
  logic              wr_hit;
  logic [NUM_PINS-1:0] pin_live;
  xbar_cfg_t         cfg_arr [NUM_PINS];

  assign offs      = addr - ADDR_W'(CFG_BASE);
  assign in_window = (addr >= ADDR_W'(CFG_BASE)) && (offs < ADDR_W'(NUM_PINS));
  assign idx       = offs[IDX_W-1:0];
  assign wr_hit    = wr_en && in_window && pin_live[idx];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit LIVE = routable(p, NUM_PINS);
    assign pin_live[p] = LIVE;
    if (LIVE) begin : g_live
      xbar_cfg_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)                               q <= CFG_RESET;
        else if (wr_hit && idx == IDX_W'(p))      q <= xbar_cfg_t'(wdata);
      end
      assign cfg_arr[p] = q;
    end else begin : g_dead
      assign cfg_arr[p] = '0;
    end
    assign cfg_flat[p*CFG_W +: CFG_W] = cfg_arr[p];
  end

  assign rdata = in_window ? cfg_arr[idx] : '0;

  // R8: a write outside the setting window touches no setting byte
  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_window) |=> $stable(cfg_flat));

  // R6: a write to a non-routable slot touches no setting byte
  p_dead_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_window && !pin_live[idx]) |=> $stable(cfg_flat));

  // R7: a stored byte reads back while the address is held
  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (!$stable(addr) || rdata == $past(wdata)));
endmodule

// File: rtl/xbar_src_sel.sv
`timescale 1ns/1ps
module xbar_src_sel import xbar_pkg::*; #(
  parameter int NUM_PINS = NUM_IO
) (
  input  logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  input  logic [NUM_PINS-1:0]       gpio_out,
  input  logic [NUM_PINS-1:0]       gpio_oe,
  input  logic [NUM_PINS-1:0]       sig_in,
  output logic [NUM_PINS-1:0]       nxt_out,
  output logic [NUM_PINS-1:0]       nxt_oe,
  output logic [NUM_PINS-1:0]       gpio_sel,
  output logic [NUM_PINS-1:0]       mux_live,
  output logic [NUM_PINS-1:0]       mux_idle
);
  localparam int SRC_SPAN = 1 << SRC_W;

  logic [SRC_SPAN-1:0] sig_ext;
  logic [SRC_SPAN-1:0] src_ok;

  assign sig_ext = {{(SRC_SPAN-NUM_PINS){1'b0}}, sig_in};

  for (genvar s = 0; s < SRC_SPAN; s++) begin : g_src
    assign src_ok[s] = routable(s, NUM_PINS);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit LIVE = routable(p, NUM_PINS);
    xbar_cfg_t c;
    logic      use_gpio;
    assign c        = cfg_flat[p*CFG_W +: CFG_W];
    // Non-routable pins are pinned to the GPIO path.
    assign use_gpio = c.gpio_mode || !LIVE;

    assign gpio_sel[p] = use_gpio;
    assign mux_live[p] = !use_gpio &&  src_ok[c.src];
    assign mux_idle[p] = !use_gpio && !src_ok[c.src];

    assign nxt_out[p] = use_gpio      ? gpio_out[p]    :
                        src_ok[c.src] ? sig_ext[c.src] : 1'b1;
    assign nxt_oe[p]  = use_gpio ? gpio_oe[p] : 1'b1;
  end
endmodule

// File: rtl/xbar_pad_stage.sv
`timescale 1ns/1ps
module xbar_pad_stage #(
  parameter int WIDTH = 84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] nxt_out,
  input  logic [WIDTH-1:0] nxt_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end
endmodule

// File: rtl/pin_xbar.sv
`timescale 1ns/1ps
module pin_xbar import xbar_pkg::*; #(
  parameter int NUM_PINS = NUM_IO,
  parameter int ADDR_W   = 8,
  parameter int CFG_BASE = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [CFG_W-1:0]    reg_wdata,
  output logic [CFG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] gpio_out,
  input  logic [NUM_PINS-1:0] gpio_oe,
  input  logic [NUM_PINS-1:0] sig_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  logic [NUM_PINS*CFG_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0] nxt_out, nxt_oe;
  logic [NUM_PINS-1:0] gpio_sel, mux_live, mux_idle;

  xbar_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg_flat(cfg_flat)
  );

  xbar_src_sel #(.NUM_PINS(NUM_PINS)) u_sel (
    .cfg_flat(cfg_flat), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .sig_in(sig_in),
    .nxt_out(nxt_out), .nxt_oe(nxt_oe),
    .gpio_sel(gpio_sel), .mux_live(mux_live), .mux_idle(mux_idle)
  );

  xbar_pad_stage #(.WIDTH(NUM_PINS)) u_pad (
    .clk(clk), .rst_n(rst_n), .nxt_out(nxt_out), .nxt_oe(nxt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R3: GPIO path reaches the pad one clock later
    p_gpio_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(gpio_sel[i])) |->
        (pad_out[i] == $past(gpio_out[i]) && pad_oe[i] == $past(gpio_oe[i])));

    // R4: a routed pin is always driven
    p_mux_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mux_live[i])) |-> pad_oe[i]);

    // R5: a bad source parks the pad high and driven
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mux_idle[i])) |-> (pad_out[i] && pad_oe[i]));

    // R4: exactly one drive path per pin
    p_one_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({gpio_sel[i], mux_live[i], mux_idle[i]}) == 1);
  end
endmodule

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;
  localparam int N = 84;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [N-1:0] gpio_out, gpio_oe, sig_in, pad_out, pad_oe;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    due;
    int    pin;
    bit    out;
    bit    oe;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_xbar u_pin_xbar (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .sig_in(sig_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Monitor: compare queued expectations at the negedge of their due count.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc) begin
        fails++;
        $display("FAIL %s pin %0d: missed due count %0d (now %0d)", e.tag, e.pin, e.due, cyc);
      end else if (pad_out[e.pin] !== e.out || pad_oe[e.pin] !== e.oe) begin
        fails++;
        $display("FAIL %s pin %0d: out/oe %b/%b expected %b/%b",
                 e.tag, e.pin, pad_out[e.pin], pad_oe[e.pin], e.out, e.oe);
      end
    end
  end

  task automatic expect_pad(int pin, bit o, bit e, int lat, string tag);
    exp_t x;
    x.due = cyc + lat; x.pin = pin; x.out = o; x.oe = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic set_sig(int n, bit v);
    @(posedge clk); #1;
    sig_in[n] = v;
  endtask

  task automatic set_gpio(int n, bit o, bit e);
    @(posedge clk); #1;
    gpio_out[n] = o; gpio_oe[n] = e;
  endtask

  task automatic rd_check(logic [7:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read 0x%02h: got 0x%02h expected 0x%02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      gpio_out[i] = (i % 3 == 0);
      gpio_oe[i]  = (i % 2 == 1);
    end
    sig_in = '0;
    idle(3);
    @(negedge clk);
    checks++;
    if (pad_out !== '0 || pad_oe !== '0) begin
      fails++;
      $display("FAIL R2 reset pads: out %h oe %h expected 0/0", pad_out, pad_oe);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    idle(2);

    // R2: reset value of setting bytes
    rd_check(8'hA1, 8'h80, "R2");
    rd_check(8'hA8, 8'h80, "R2");

    // R3: GPIO path with default setting
    set_gpio(33, 1'b0, 1'b1); expect_pad(33, 1'b0, 1'b1, 1, "R3"); idle(3);
    set_gpio(33, 1'b1, 1'b0); expect_pad(33, 1'b1, 1'b0, 1, "R3"); idle(3);

    // R1/R9: route I/O 5 onto pin 33; old path holds until the following edge
    wr(8'hA1, 8'h05);
    expect_pad(33, 1'b1, 1'b0, 0, "R9");
    expect_pad(33, 1'b0, 1'b1, 1, "R1");
    idle(3);
    set_sig(5, 1'b1); expect_pad(33, 1'b1, 1'b1, 1, "R4"); idle(3);
    set_sig(5, 1'b0); expect_pad(33, 1'b0, 1'b1, 1, "R9"); idle(3);
    rd_check(8'hA1, 8'h05, "R7");

    // R5: bad sources on pin 40 (gpio 0/0)
    wr(8'hA8, 8'h7F); expect_pad(40, 1'b1, 1'b1, 1, "R5"); idle(3);
    rd_check(8'hA8, 8'h7F, "R7");
    wr(8'hA8, 8'h05); expect_pad(40, 1'b0, 1'b1, 1, "R4"); idle(3);
    wr(8'hA8, 8'h12); expect_pad(40, 1'b1, 1'b1, 1, "R5"); idle(3);
    wr(8'hA8, 8'h05); expect_pad(40, 1'b0, 1'b1, 1, "R4"); idle(3);
    wr(8'hA8, 8'h54); expect_pad(40, 1'b1, 1'b1, 1, "R5"); idle(3);
    wr(8'hA8, 8'h05); expect_pad(40, 1'b0, 1'b1, 1, "R4"); idle(3);
    wr(8'hA8, 8'h00); expect_pad(40, 1'b1, 1'b1, 1, "R5"); idle(3);
    wr(8'hA8, 8'h05); expect_pad(40, 1'b0, 1'b1, 1, "R4"); idle(3);
    wr(8'hA8, 8'h03); expect_pad(40, 1'b1, 1'b1, 1, "R5"); idle(3);

    // R6: non-routable pins keep GPIO control and read zero
    set_sig(5, 1'b1);
    set_gpio(3, 1'b0, 1'b0);
    set_gpio(18, 1'b0, 1'b0);
    idle(2);
    wr(8'h83, 8'h05); expect_pad(3, 1'b0, 1'b0, 1, "R6"); idle(3);
    rd_check(8'h83, 8'h00, "R6");
    wr(8'h92, 8'h05); expect_pad(18, 1'b0, 1'b0, 1, "R6"); idle(3);
    rd_check(8'h92, 8'h00, "R6");
    wr(8'hD5, 8'h05); rd_check(8'hD5, 8'h00, "R6");
    wr(8'h80, 8'h05); rd_check(8'h80, 8'h00, "R6");

    // R8: writes below the window change nothing
    wr(8'h21, 8'h85); expect_pad(33, 1'b1, 1'b1, 1, "R8"); idle(3);
    rd_check(8'hA1, 8'h05, "R8");
    wr(8'h28, 8'h80); rd_check(8'hA8, 8'h03, "R8");

    // R3: back to GPIO mode, source bits ignored (pin 33 gpio 1/0)
    wr(8'hA1, 8'h85); expect_pad(33, 1'b1, 1'b0, 1, "R3"); idle(3);
    rd_check(8'hA1, 8'h85, "R7");
    set_sig(5, 1'b0); expect_pad(33, 1'b1, 1'b0, 1, "R3"); idle(3);

    // R4: pins at both ends of the range, cross-routed
    wr(8'h81, 8'h53);
    wr(8'hD3, 8'h01);
    set_sig(83, 1'b1);
    expect_pad(1, 1'b1, 1'b1, 1, "R4");
    expect_pad(83, 1'b0, 1'b1, 1, "R4");
    idle(3);
    set_sig(83, 1'b0); set_sig(1, 1'b1);
    expect_pad(1, 1'b0, 1'b1, 1, "R4");
    expect_pad(83, 1'b1, 1'b1, 1, "R4");
    idle(3);

    // R4: source is the raw input, not pin 33's pad (pad 33 is 1/0)
    set_sig(33, 1'b0);
    wr(8'h9D, 8'h21); expect_pad(29, 1'b0, 1'b1, 1, "R4"); idle(3);
    set_sig(33, 1'b1); expect_pad(29, 1'b1, 1'b1, 1, "R4"); idle(3);

    idle(4);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL queue: %0d expectations never compared, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(20000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule